// File: doc/BRIEF.md
# Pin Level-Change Detector

This block watches one general-purpose pin of a serial port and reports when its level changes. On every rising edge of the module clock it compares the pin with the value it stored at the previous edge. Any difference, whether low to high or high to low, sets a sticky status flag. The flag stays set until software clears it.

An enable input decides only whether the flag drives the interrupt output. The flag records changes even while the enable is low. Software clears the flag by writing a 1 to a write-only action bit, which always reads back as 0. A readback output shows the live level of the pin at all times. The pin is assumed to be synchronous to the module clock already.

Top module: `pin_change_watch`

## Requirements
- R1: A low-to-high change of `pin_i` between two clock edges sets `chg_sts_o` to 1 after the second of those edges.
- R2: A high-to-low change of `pin_i` between two clock edges sets `chg_sts_o` to 1 after the second of those edges.
- R3: Once set, `chg_sts_o` stays at 1 until it is cleared. The stored value is updated on every edge, so a pin held at a steady level after a change produces no further detection after a clear.
- R4: A detected change sets `chg_sts_o` even while `irq_en_i` is 0.
- R5: `irq_o` is 1 exactly when `chg_sts_o` is 1 and `irq_en_i` is 1. Dropping `irq_en_i` masks `irq_o` at once and leaves `chg_sts_o` unchanged.
- R6: A write cycle with `clr_wr_i`=1 and `clr_data_i`=1 clears `chg_sts_o` at that clock edge. A write with `clr_data_i`=0 has no effect on the flag.
- R7: `clr_rd_o`, the readback of the clear action bit, is always 0.
- R8: If a clear write and a new pin change fall on the same clock edge, the change wins and `chg_sts_o` stays at 1.
- R9: While `rst_n` is 0 at a clock edge, `chg_sts_o` becomes 0 and the stored value takes the current pin level. A pin that is high through reset and stays high therefore reports no change.
- R10: `pin_lvl_o` follows `pin_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock; the pin is sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_i | input | 1 | Watched pin, already synchronous to `clk` |
| irq_en_i | input | 1 | Interrupt enable for the change flag |
| clr_wr_i | input | 1 | Write strobe for the clear action bit |
| clr_data_i | input | 1 | Data bit written to the clear action bit |
| chg_sts_o | output | 1 | Sticky change-detected flag |
| irq_o | output | 1 | Interrupt request |
| pin_lvl_o | output | 1 | Live level of the watched pin |
| clr_rd_o | output | 1 | Readback of the clear action bit, always 0 |

## Verification
A wrong stored pin value shows at `chg_sts_o` one edge later: either as a false detection on a steady pin, or as a missed detection after a real change. A flag that fails to hold or to clear appears on `chg_sts_o`, and through `irq_o` when enabled, immediately after the edge that should have kept or cleared it. The bench therefore samples both outputs one edge after each stimulus. It covers both change directions, the masked and unmasked enable, the clear with data 0 and with data 1, and a clear on the same edge as a change.

// File: rtl/pin_change_watch.sv
module pin_change_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic irq_en_i,
  input  logic clr_wr_i,
  input  logic clr_data_i,
  output logic chg_sts_o,
  output logic irq_o,
  output logic pin_lvl_o,
  output logic clr_rd_o
);

  logic prev_q;
  logic sts_q;
  logic edge_seen;
  logic clr_hit;

  assign edge_seen = pin_i ^ prev_q;
  assign clr_hit   = clr_wr_i & clr_data_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= pin_i;
      sts_q  <= 1'b0;
    end else begin
      prev_q <= pin_i;
      sts_q  <= edge_seen | (sts_q & ~clr_hit);
    end
  end

  assign chg_sts_o = sts_q;
  assign irq_o     = sts_q & irq_en_i;
  assign pin_lvl_o = pin_i;
  assign clr_rd_o  = 1'b0;

  // R1 R2
  any_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_i != $past(pin_i)) |=> chg_sts_o);

  // R3 R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_sts_o && !(clr_wr_i && clr_data_i)) |=> chg_sts_o);

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr_i && clr_data_i && pin_i == $past(pin_i)) |=> !chg_sts_o);

  // R3
  no_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg_sts_o && pin_i == $past(pin_i)) |=> !chg_sts_o);

  // R9
  reset_clr_chk: assert property (@(posedge clk)
    !rst_n |=> !chg_sts_o);

endmodule

// File: tb/sim_pin_change_watch.sv
`timescale 1ns/1ps
module sim_pin_change_watch;
  logic clk = 1'b0;
  logic rst_n, pin, en, clr_wr, clr_data;
  logic sts, irq, lvl, clr_rd;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pin_change_watch u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .irq_en_i(en),
    .clr_wr_i(clr_wr), .clr_data_i(clr_data),
    .chg_sts_o(sts), .irq_o(irq), .pin_lvl_o(lvl), .clr_rd_o(clr_rd)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pin = 1'b1; en = 1'b0; clr_wr = 1'b0; clr_data = 1'b0;
    tick(3);
    chk(sts, 1'b0, "R9 flag low in reset");
    rst_n = 1'b1;
    tick(2);
    chk(sts, 1'b0, "R9 no false change with pin high through reset");
    chk(lvl, 1'b1, "R10 readback high");
    chk(clr_rd, 1'b0, "R7 action bit reads 0");
  endtask

  task automatic t_fall_masked;
    pin = 1'b0;
    #1;
    chk(lvl, 1'b0, "R10 readback follows pin at once");
    chk(sts, 1'b0, "R2 flag not set before edge");
    tick();
    chk(sts, 1'b1, "R2 falling change sets flag");
    chk(irq, 1'b0, "R4 flag set with enable low, irq masked");
    tick(3);
    chk(sts, 1'b1, "R3 flag sticky on steady pin");
  endtask

  task automatic t_clear;
    clr_wr = 1'b1; clr_data = 1'b0;
    tick();
    chk(sts, 1'b1, "R6 write of 0 leaves flag");
    clr_data = 1'b1;
    #1;
    chk(clr_rd, 1'b0, "R7 action bit reads 0 during write");
    tick();
    clr_wr = 1'b0; clr_data = 1'b0;
    chk(sts, 1'b0, "R6 write of 1 clears flag");
    tick(2);
    chk(sts, 1'b0, "R3 steady pin gives single detection");
  endtask

  task automatic t_rise_irq;
    en = 1'b1;
    pin = 1'b1;
    tick();
    chk(sts, 1'b1, "R1 rising change sets flag");
    chk(irq, 1'b1, "R5 irq with enable high");
    en = 1'b0;
    #1;
    chk(irq, 1'b0, "R5 irq masked when enable drops");
    chk(sts, 1'b1, "R5 flag kept when enable drops");
    en = 1'b1;
    #1;
    chk(irq, 1'b1, "R5 irq returns with enable");
    clr_wr = 1'b1; clr_data = 1'b1;
    tick();
    clr_wr = 1'b0; clr_data = 1'b0;
    chk(sts, 1'b0, "R6 clear after rise");
    chk(irq, 1'b0, "R5 irq low once flag cleared");
  endtask

  task automatic t_collide;
    pin = 1'b0; clr_wr = 1'b1; clr_data = 1'b1;
    tick();
    clr_wr = 1'b0; clr_data = 1'b0;
    chk(sts, 1'b1, "R8 change wins over clear on same edge");
    clr_wr = 1'b1; clr_data = 1'b1;
    tick();
    clr_wr = 1'b0; clr_data = 1'b0;
    chk(sts, 1'b0, "R8 later clear takes effect");
    pin = 1'b1;
    tick();
    pin = 1'b0;
    tick();
    chk(sts, 1'b1, "R1 R2 back-to-back changes keep flag");
  endtask

  initial begin
    t_reset();
    t_fall_masked();
    t_clear();
    t_rise_irq();
    t_collide();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule